// File: doc/BRIEF.md
# ADC Oversampling Accumulator with Rounding

This block follows a 12-bit successive-approximation conversion engine. It adds up a programmable number of consecutive raw results for each channel. The number of results per output is a power of two from 2 to 256. The block then divides the total by a programmable power of two from 1 to 256, rounding to the nearest integer, and delivers a 16-bit value. If the divide does not bring the total down to 16 bits, only the low 16 bits are kept and nothing signals the wrap.

Three registered event pulses follow the oversampling cadence. An end-of-sample pulse comes after every sampling phase. An end-of-conversion pulse comes once per completed run. An end-of-sequence pulse comes when the last channel of a multi-channel sequence finishes its run. A sequence-start strobe discards any partial total and returns the sample count and the channel index to zero. The result arrives one clock after the last raw sample of its run, so oversampling adds no latency beyond the accumulation itself.

Top module: `adc_ovs_accum`

## Requirements
- R1: The 3-bit `cfg_ratio` code k selects N = 2^(k+1) raw samples per result (code 0 gives 2, code 7 gives 256). No result is produced before the Nth `raw_vld` pulse of a run.
- R2: The 4-bit `cfg_shift` code s (0 to 8) divides the run total by 2^s. Codes 9 to 15 behave as 8.
- R3: Before the shift, 2^(s-1) is added to the total when s > 0, and nothing is added when s = 0. Halves therefore round up; for example, a total of 0x1FFE with s=2 gives 0x0800.
- R4: `res_data_o` carries bits 15:0 of the rounded and shifted value, and higher bits are dropped. For example, 32 samples of 0xFFF with s=0 give 0xFFE0.
- R5: `eosmp_o` is high for exactly the one cycle after each cycle in which `smp_done` is high, whatever the state of the accumulation.
- R6: `eoc_o` and `res_vld_o` are high for one cycle, in the cycle after the Nth `raw_vld` of a run. The new `res_data_o` is valid in that same cycle.
- R7: `res_data_o` keeps its value in every cycle that does not carry an end-of-conversion pulse.
- R8: With `cfg_seq_len_m1` = L, a sequence has L+1 channels. `eos_o` rises together with `eoc_o` only for the run of channel L, after which the channel index returns to 0.
- R9: A `seq_start` pulse discards the partial total, the sample count and the channel index. A `raw_vld` in the same cycle becomes the first sample of channel 0 of the new sequence.
- R10: After a synchronous reset, all outputs are 0.
- R11: Each result contains only the samples of its own run. The total is cleared when each result is produced, so consecutive channels do not mix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start | input | 1 | Start of a new conversion sequence |
| smp_done | input | 1 | Sampling phase finished strobe |
| raw_vld | input | 1 | Raw conversion result valid strobe |
| raw_data | input | 12 | Raw conversion result |
| cfg_ratio | input | 3 | Oversampling ratio code, N = 2^(code+1) |
| cfg_shift | input | 4 | Right-shift amount, 0 to 8 (larger codes clamp to 8) |
| cfg_seq_len_m1 | input | 4 | Number of channels in the sequence minus one |
| eosmp_o | output | 1 | End-of-sampling pulse |
| eoc_o | output | 1 | End-of-conversion pulse, once per N samples |
| eos_o | output | 1 | End-of-sequence pulse |
| res_vld_o | output | 1 | Result valid, coincident with end-of-conversion |
| res_data_o | output | 16 | Rounded, shifted and truncated result |

## Verification
The end-of-sample pulse and the end-of-conversion pulse can land in the same cycle. This happens when a sampling-done strobe arrives together with the last raw sample of a run. The bench provokes this by raising `smp_done` on every `raw_vld` of a four-sample run, and it requires both pulses high together after the final sample, with the exact total. The bench also makes a sequence restart coincide with a data strobe. It then checks that only the samples from that cycle onward reach the next result, and that the channel index has returned to 0.

// File: rtl/adc_ovs_pkg.sv
package adc_ovs_pkg;
  localparam int RAW_W_DEF     = 12;
  localparam int RATIO_W_DEF   = 3;
  localparam int SHIFT_W_DEF   = 4;
  localparam int MAX_SHIFT_DEF = 8;
  localparam int CH_W_DEF      = 4;
  localparam int OUT_W_DEF     = 16;

  typedef struct packed {
    logic eosmp;
    logic eoc;
    logic eos;
  } ovs_flags_t;
endpackage

// File: rtl/adc_ovs_sample_ctr.sv
module adc_ovs_sample_ctr #(
  parameter int RATIO_W = 3,
  parameter int CNT_W   = 8,
  parameter int CH_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               seq_start,
  input  logic               raw_vld,
  input  logic [RATIO_W-1:0] ratio_code,
  input  logic [CH_W-1:0]    seq_len_m1,
  output logic               run_last,
  output logic               seq_last
);
  logic [CNT_W-1:0] cnt_q, base_cnt, ratio_m1;
  logic [CH_W-1:0]  ch_q, base_ch;
  logic [CNT_W:0]   n_full;
  logic [RATIO_W:0] shamt;

  always_comb begin
    shamt    = {1'b0, ratio_code} + (RATIO_W+1)'(1);
    n_full   = (CNT_W+1)'(1) << shamt;
    ratio_m1 = CNT_W'(n_full - (CNT_W+1)'(1));
    base_cnt = seq_start ? '0 : cnt_q;
    base_ch  = seq_start ? '0 : ch_q;
    run_last = (base_cnt == ratio_m1);
    seq_last = (base_ch == seq_len_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ch_q  <= '0;
    end else if (raw_vld) begin
      if (run_last) begin
        cnt_q <= '0;
        ch_q  <= seq_last ? '0 : base_ch + CH_W'(1);
      end else begin
        cnt_q <= base_cnt + CNT_W'(1);
        ch_q  <= base_ch;
      end
    end else if (seq_start) begin
      cnt_q <= '0;
      ch_q  <= '0;
    end
  end

  // R1: the sample index never passes the end of the selected run
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= ratio_m1);
endmodule

// File: rtl/adc_ovs_acc_core.sv
module adc_ovs_acc_core #(
  parameter int RAW_W = 12,
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seq_start,
  input  logic             raw_vld,
  input  logic [RAW_W-1:0] raw_data,
  input  logic             run_last,
  output logic [ACC_W-1:0] sum_now
);
  logic [ACC_W-1:0] acc_q, base;

  always_comb begin
    base    = seq_start ? '0 : acc_q;
    sum_now = base + ACC_W'(raw_data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (raw_vld) begin
      acc_q <= run_last ? '0 : sum_now;
    end else if (seq_start) begin
      acc_q <= '0;
    end
  end

  // R11: the total starts afresh after every completed run
  p_acc_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (raw_vld && run_last) |=> (acc_q == '0));
endmodule

// File: rtl/adc_ovs_round_shift.sv
module adc_ovs_round_shift #(
  parameter int ACC_W     = 20,
  parameter int OUT_W     = 16,
  parameter int SHIFT_W   = 4,
  parameter int MAX_SHIFT = 8
) (
  input  logic [ACC_W-1:0]   sum_in,
  input  logic [SHIFT_W-1:0] shift_code,
  output logic [OUT_W-1:0]   res
);
  localparam int QW = (ACC_W + 1 > OUT_W) ? ACC_W + 1 : OUT_W;

  logic [SHIFT_W-1:0] sh;
  logic [QW-1:0]      ext, rnd, q;

  always_comb begin
    sh  = (shift_code > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : shift_code;
    ext = QW'(sum_in);
    rnd = (sh == '0) ? '0 : (QW'(1) << (sh - SHIFT_W'(1)));
    q   = (ext + rnd) >> sh;
    res = OUT_W'(q);
  end
endmodule

// File: rtl/adc_ovs_accum.sv
module adc_ovs_accum
  import adc_ovs_pkg::*;
#(
  parameter int RAW_W     = RAW_W_DEF,
  parameter int RATIO_W   = RATIO_W_DEF,
  parameter int SHIFT_W   = SHIFT_W_DEF,
  parameter int MAX_SHIFT = MAX_SHIFT_DEF,
  parameter int CH_W      = CH_W_DEF,
  parameter int OUT_W     = OUT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               seq_start,
  input  logic               smp_done,
  input  logic               raw_vld,
  input  logic [RAW_W-1:0]   raw_data,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [CH_W-1:0]    cfg_seq_len_m1,
  output logic               eosmp_o,
  output logic               eoc_o,
  output logic               eos_o,
  output logic               res_vld_o,
  output logic [OUT_W-1:0]   res_data_o
);
  localparam int CNT_W = 1 << RATIO_W;
  localparam int ACC_W = RAW_W + CNT_W;

  logic             run_last, seq_last;
  logic [ACC_W-1:0] sum_now;
  logic [OUT_W-1:0] rounded;
  ovs_flags_t       flags_q;
  logic [OUT_W-1:0] res_q;

  adc_ovs_sample_ctr #(.RATIO_W(RATIO_W), .CNT_W(CNT_W), .CH_W(CH_W)) u_ctr (
    .clk(clk), .rst(rst), .seq_start(seq_start), .raw_vld(raw_vld),
    .ratio_code(cfg_ratio), .seq_len_m1(cfg_seq_len_m1),
    .run_last(run_last), .seq_last(seq_last)
  );

  adc_ovs_acc_core #(.RAW_W(RAW_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .seq_start(seq_start), .raw_vld(raw_vld),
    .raw_data(raw_data), .run_last(run_last), .sum_now(sum_now)
  );

  adc_ovs_round_shift #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W),
                        .MAX_SHIFT(MAX_SHIFT)) u_rnd (
    .sum_in(sum_now), .shift_code(cfg_shift), .res(rounded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      res_q   <= '0;
    end else begin
      flags_q.eosmp <= smp_done;
      flags_q.eoc   <= raw_vld & run_last;
      flags_q.eos   <= raw_vld & run_last & seq_last;
      if (raw_vld && run_last) res_q <= rounded;
    end
  end

  assign eosmp_o    = flags_q.eosmp;
  assign eoc_o      = flags_q.eoc;
  assign eos_o      = flags_q.eos;
  assign res_vld_o  = flags_q.eoc;
  assign res_data_o = res_q;

  // R8: end of sequence only together with an end of conversion
  p_eos_with_eoc_r8: assert property (@(posedge clk) disable iff (rst)
    eos_o |-> eoc_o);

  // R7: result holds outside end-of-conversion cycles
  p_res_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !eoc_o |-> $stable(res_data_o));
endmodule

// File: tb/sim_adc_ovs_accum.sv
module sim_adc_ovs_accum;
  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seq_start = 1'b0, smp_done = 1'b0, raw_vld = 1'b0;
  logic [11:0] raw_data = '0;
  logic [2:0]  cfg_ratio = '0;
  logic [3:0]  cfg_shift = '0;
  logic [3:0]  cfg_seq_len_m1 = '0;
  logic        eosmp_o, eoc_o, eos_o, res_vld_o;
  logic [15:0] res_data_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_ovs_accum u0 (
    .clk(clk), .rst(rst), .seq_start(seq_start), .smp_done(smp_done),
    .raw_vld(raw_vld), .raw_data(raw_data), .cfg_ratio(cfg_ratio),
    .cfg_shift(cfg_shift), .cfg_seq_len_m1(cfg_seq_len_m1),
    .eosmp_o(eosmp_o), .eoc_o(eoc_o), .eos_o(eos_o),
    .res_vld_o(res_vld_o), .res_data_o(res_data_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int ref_res(input longint sum, input int shift);
    int s;
    longint r;
    s = (shift > 8) ? 8 : shift;
    r = (s == 0) ? sum : ((sum + (longint'(1) << (s - 1))) >> s);
    return int'(r & 64'hFFFF);
  endfunction

  task automatic cfg(input int ratio, input int shift, input int len_m1);
    @(negedge clk);
    cfg_ratio = 3'(ratio); cfg_shift = 4'(shift); cfg_seq_len_m1 = 4'(len_m1);
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
  endtask

  task automatic push(input logic [11:0] d, input bit smp, input bit ss);
    @(negedge clk);
    raw_vld = 1'b1; raw_data = d; smp_done = smp; seq_start = ss;
    @(negedge clk);
    raw_vld = 1'b0; smp_done = 1'b0; seq_start = 1'b0;
  endtask

  task automatic push_n(input int n, input logic [11:0] d);
    for (int i = 0; i < n; i++) push(d, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 eosmp", eosmp_o, 0);
    chk("R10 eoc", eoc_o, 0);
    chk("R10 eos", eos_o, 0);
    chk("R10 res_vld", res_vld_o, 0);
    chk("R10 res_data", res_data_o, 0);
  endtask

  task automatic t_round;
    cfg(0, 2, 0);
    push(12'hFFF, 0, 0);
    chk("R6 no eoc mid-run", eoc_o, 0);
    push(12'hFFF, 0, 0);
    chk("R6 eoc", eoc_o, 1);
    chk("R6 res_vld", res_vld_o, 1);
    chk("R3 1FFE>>2", res_data_o, 16'h0800);
    chk("R8 single channel eos", eos_o, 1);
    @(negedge clk);
    chk("R6 eoc single cycle", eoc_o, 0);
    cfg(0, 3, 0);
    push_n(2, 12'hFFF);
    chk("R3 1FFE>>3", res_data_o, 16'h0400);
    cfg(0, 1, 0);
    push(12'h001, 0, 0); push(12'h002, 0, 0);
    chk("R3 half rounds up", res_data_o, ref_res(3, 1));
    cfg(0, 0, 0);
    push(12'h001, 0, 0); push(12'h002, 0, 0);
    chk("R3 no add at shift 0", res_data_o, 3);
  endtask

  task automatic t_trunc;
    cfg(4, 0, 0);
    push_n(32, 12'hFFF);
    chk("R4 ratio 32 no shift", res_data_o, 16'hFFE0);
    cfg(7, 8, 0);
    push_n(255, 12'hFFF);
    chk("R1 no eoc at 255 of 256", eoc_o, 0);
    push(12'hFFF, 0, 0);
    chk("R1 eoc at 256", eoc_o, 1);
    chk("R1 256x shift 8", res_data_o, 16'h0FFF);
    cfg(7, 0, 0);
    push_n(256, 12'hFFF);
    chk("R4 256x no shift", res_data_o, ref_res(64'hFFF00, 0));
  endtask

  task automatic t_clamp;
    cfg(0, 15, 0);
    push_n(2, 12'h800);
    chk("R2 code 15 acts as 8", res_data_o, ref_res(64'h1000, 8));
    cfg(0, 9, 0);
    push_n(2, 12'h7FF);
    chk("R2 code 9 acts as 8", res_data_o, ref_res(64'h0FFE, 8));
  endtask

  task automatic t_hold;
    int held;
    held = res_data_o;
    push(12'h800, 0, 0);
    chk("R7 hold after mid-run sample", res_data_o, held);
    chk("R6 res_vld low mid-run", res_vld_o, 0);
    @(negedge clk);
    chk("R7 hold while idle", res_data_o, held);
    push(12'h000, 0, 0);
    chk("R7 update at eoc", res_data_o, ref_res(64'h800, 8));
  endtask

  task automatic t_flags;
    @(negedge clk);
    smp_done = 1'b1;
    @(negedge clk);
    smp_done = 1'b0;
    chk("R5 eosmp after strobe", eosmp_o, 1);
    chk("R5 no eoc from sampling", eoc_o, 0);
    @(negedge clk);
    chk("R5 eosmp one cycle", eosmp_o, 0);
    cfg(1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      push(12'(5 + i), 1'b1, 1'b0);
      chk("R5 eosmp in run", eosmp_o, 1);
    end
    push(12'd8, 1'b1, 1'b0);
    chk("R5 eosmp with eoc", eosmp_o, 1);
    chk("R6 eoc with eosmp", eoc_o, 1);
    chk("R6 sum of run", res_data_o, 26);
  endtask

  task automatic t_seq;
    cfg(1, 2, 2);
    push_n(4, 12'h100);
    chk("R11 ch0 result", res_data_o, 16'h0100);
    chk("R8 no eos ch0", eos_o, 0);
    push_n(3, 12'h001); push(12'h002, 0, 0);
    chk("R11 ch1 independent", res_data_o, ref_res(5, 2));
    chk("R8 no eos ch1", eos_o, 0);
    push_n(4, 12'hFFF);
    chk("R11 ch2 result", res_data_o, 16'h0FFF);
    chk("R8 eos last channel", eos_o, 1);
    push_n(4, 12'h004);
    chk("R8 wrap to ch0 no eos", eos_o, 0);
    chk("R11 ch0 after wrap", res_data_o, 4);
  endtask

  task automatic t_restart;
    cfg(1, 0, 1);
    push_n(3, 12'hFFF);
    push(12'h010, 0, 1);
    chk("R9 no eoc at restart", eoc_o, 0);
    push_n(2, 12'h010);
    chk("R9 no eoc before fourth", eoc_o, 0);
    push(12'h010, 0, 0);
    chk("R9 partial discarded", res_data_o, 16'h0040);
    chk("R9 eoc counted from restart", eoc_o, 1);
    chk("R9 channel 0 no eos", eos_o, 0);
    push_n(4, 12'h001);
    chk("R8 ch1 eos", eos_o, 1);
    push_n(4, 12'h002);
    cfg(1, 0, 1);
    push_n(4, 12'h003);
    chk("R9 channel index reset", eos_o, 0);
    chk("R9 result after restart", res_data_o, 12);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_round();
    t_trunc();
    t_clamp();
    t_hold();
    t_flags();
    t_seq();
    t_restart();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule